// File: doc/BRIEF.md
# Reset Oscillator Start-up Sequencer

This block brings a microcontroller core out of reset in a fixed, repeatable order. Two things start it: the power-on reset (`rst_n` low) and a synchronous reset request from any other source. Either one returns the clock-select output to the primary clock and clears the oscillator-stable flag. The block then holds the core in reset while two start-up timers run side by side.

The first timer is the oscillator start-up counter. It runs only when the primary source is one of the three crystal modes, and it counts primary-clock tick strobes. The second timer is a CPU start-up delay, counted in block-clock cycles. It runs after a power-on reset, and after a reset request that arrives while the core is asleep. When both timers are done, the block waits one extra settling cycle. It then releases the core. The run enable stays high until the next reset.

An optional two-speed start-up makes the internal RC clock the system clock while the crystal count is in progress. All pins are plain level controls or status bits. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `rst_osc_seq`

## Requirements
- R1: One clock edge after `reset_req` is sampled high, and at once while `rst_n` is low, the outputs are `hold_rst`=1, `run_en`=0, `clk_sel`=00 and `osc_stable`=0.
- R2: In a crystal mode (`osc_mode` 000 low-power, 001 standard, 010 high-speed), `osc_stable` rises on the clock edge that brings the tick count to `OST_TICKS`. With a tick on every cycle, this is edge `OST_TICKS`+1 after the last edge of the reset state.
- R3: In any other mode (011 external clock, 100 external RC, 101 internal RC, and 110/111), there is no oscillator count, and `osc_stable` rises on the first edge after the reset state ends.
- R4: The CPU delay of `CPU_TICKS` cycles runs after a power-on reset. It also runs after a `reset_req` taken while `sleep_i`=1. After a `reset_req` taken while `sleep_i`=0 it is skipped.
- R5: The two timers run in parallel. `run_en` rises max(d_osc, d_cpu)+2 edges after the reset state ends. Here d_osc is `OST_TICKS`+1 in crystal modes with ticks every cycle, or 1 otherwise, and d_cpu is `CPU_TICKS`+1 when the delay runs, or 1 otherwise.
- R6: After the last timer finishes, one extra settling cycle passes before release. `run_en` is never high on the cycle in which `osc_stable` first becomes high.
- R7: `hold_rst` is the inverse of `run_en`. Once high, `run_en` stays high until the next reset.
- R8: With `two_speed_en`=1 in a crystal mode, `clk_sel` is 10 (internal RC) while the crystal count is in progress and 00 from the moment `osc_stable` rises. In every other case `clk_sel` is 00.
- R9: `osc_mode` and `two_speed_en` are taken on the last edge of the reset state. Later changes have no effect until the next reset.
- R10: The oscillator start-up count advances only on cycles with `prim_tick`=1. Without ticks, `osc_stable` and `run_en` stay low.
- R11: A new `reset_req` during the wait restarts both timers from zero.
- R12: A `reset_req` held for several cycles keeps the block in reset. All start-up timing counts from the last cycle in which it was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block reference clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| reset_req | input | 1 | Synchronous reset request from any source |
| osc_mode | input | 3 | Primary oscillator mode code |
| sleep_i | input | 1 | Core is in sleep when the reset request arrives |
| two_speed_en | input | 1 | Run from internal RC while the crystal starts |
| prim_tick | input | 1 | One-cycle strobe per primary-clock cycle |
| hold_rst | output | 1 | Core held in reset, clocks parked in the first phase |
| run_en | output | 1 | Instruction execution released |
| clk_sel | output | 2 | System clock select: 00 primary, 10 internal RC |
| osc_stable | output | 1 | Oscillator start-up count complete |

## Verification
The clear outputs are due one edge after a reset request. The stable flag is due 1 or `OST_TICKS`+1 edges after the reset state ends, and the run enable is due two edges after the later of the two timers. For each reset it issues, the driver computes these offsets from the requirements and records the cycle count of the last reset edge. It then queues the expected offsets together with the `clk_sel` value due just before the stable flag rises. The monitor samples on the falling edge, so every output has settled one half-period after the register that drives it. It compares the cycle distance of each rising flag with the queued offset, and the no-tick case is counted out edge by edge from the falling edge on which ticks resume.

// File: rtl/rst_osc_pkg.sv
package rst_osc_pkg;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_WAIT  = 2'd1,
    ST_EXTRA = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_t;

  localparam int unsigned MODE_W = 3;
  localparam int unsigned SEL_W  = 2;

  localparam logic [MODE_W-1:0] MODE_LP    = 3'd0;
  localparam logic [MODE_W-1:0] MODE_XT    = 3'd1;
  localparam logic [MODE_W-1:0] MODE_HS    = 3'd2;
  localparam logic [MODE_W-1:0] MODE_EC    = 3'd3;
  localparam logic [MODE_W-1:0] MODE_ERC   = 3'd4;
  localparam logic [MODE_W-1:0] MODE_INTRC = 3'd5;

  localparam logic [SEL_W-1:0] SEL_PRIMARY = 2'b00;
  localparam logic [SEL_W-1:0] SEL_INTRC   = 2'b10;

  function automatic logic mode_is_crystal(input logic [MODE_W-1:0] m);
    return (m == MODE_LP) || (m == MODE_XT) || (m == MODE_HS);
  endfunction

endpackage

// File: rtl/rst_osc_delay.sv
module rst_osc_delay #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic enable,
  input  logic step,
  output logic done
);
  localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  // Saturating count: stops at the limit so done stays high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (enable && step && (cnt != LIM)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // A disabled timer counts as already expired.
  assign done = !enable || (cnt == LIM);
endmodule

// File: rtl/rst_osc_cfg.sv
module rst_osc_cfg
  import rst_osc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_req,
  input  logic              load,
  input  logic [MODE_W-1:0] osc_mode,
  input  logic              sleep_i,
  input  logic              two_speed_en,
  output logic              xtal_q,
  output logic              fallback_q,
  output logic              cpu_en_q
);
  // Mode and fallback follow the inputs while in reset, then freeze.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xtal_q     <= 1'b0;
      fallback_q <= 1'b0;
    end else if (load) begin
      xtal_q     <= mode_is_crystal(osc_mode);
      fallback_q <= two_speed_en;
    end
  end

  // Power-on always runs the CPU delay; a request runs it only from sleep.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_en_q <= 1'b1;
    end else if (reset_req) begin
      cpu_en_q <= sleep_i;
    end
  end
endmodule

// File: rtl/rst_osc_fsm.sv
module rst_osc_fsm
  import rst_osc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reset_req,
  input  logic       cpu_done,
  input  logic       ost_done,
  output seq_state_t state
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    if (reset_req) begin
      nxt = ST_RESET;
    end else begin
      unique case (state)
        ST_RESET: nxt = ST_WAIT;
        ST_WAIT:  if (cpu_done && ost_done) nxt = ST_EXTRA;
        ST_EXTRA: nxt = ST_RUN;
        ST_RUN:   nxt = ST_RUN;
        default:  nxt = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= nxt;
  end
endmodule

// File: rtl/rst_osc_seq.sv
module rst_osc_seq
  import rst_osc_pkg::*;
#(
  parameter int unsigned OST_TICKS = 1024,
  parameter int unsigned CPU_TICKS = 1600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_req,
  input  logic [MODE_W-1:0] osc_mode,
  input  logic              sleep_i,
  input  logic              two_speed_en,
  input  logic              prim_tick,
  output logic              hold_rst,
  output logic              run_en,
  output logic [SEL_W-1:0]  clk_sel,
  output logic              osc_stable
);
  seq_state_t state;
  logic in_reset;
  logic xtal_q, fallback_q, cpu_en_q;
  logic ost_done, cpu_done;

  assign in_reset = (state == ST_RESET);

  rst_osc_cfg u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .reset_req    (reset_req),
    .load         (in_reset),
    .osc_mode     (osc_mode),
    .sleep_i      (sleep_i),
    .two_speed_en (two_speed_en),
    .xtal_q       (xtal_q),
    .fallback_q   (fallback_q),
    .cpu_en_q     (cpu_en_q)
  );

  rst_osc_delay #(.LIMIT(OST_TICKS)) u_ost (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (in_reset),
    .enable (xtal_q),
    .step   (prim_tick),
    .done   (ost_done)
  );

  rst_osc_delay #(.LIMIT(CPU_TICKS)) u_cpu (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (in_reset),
    .enable (cpu_en_q),
    .step   (1'b1),
    .done   (cpu_done)
  );

  rst_osc_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_req (reset_req),
    .cpu_done  (cpu_done),
    .ost_done  (ost_done),
    .state     (state)
  );

  assign hold_rst   = (state != ST_RUN);
  assign run_en     = (state == ST_RUN);
  assign osc_stable = !in_reset && ost_done;
  assign clk_sel    = ((state == ST_WAIT) && fallback_q && xtal_q && !ost_done)
                      ? SEL_INTRC : SEL_PRIMARY;
endmodule

// File: rtl/rst_osc_seq_chk.sv
module rst_osc_seq_chk
  import rst_osc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reset_req,
  input logic [MODE_W-1:0] osc_mode,
  input logic              sleep_i,
  input logic              two_speed_en,
  input logic              prim_tick,
  input logic              hold_rst,
  input logic              run_en,
  input logic [SEL_W-1:0]  clk_sel,
  input logic              osc_stable
);
  p_clear_on_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (clk_sel == SEL_PRIMARY) && !osc_stable && hold_rst && !run_en);

  p_stable_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stable && !reset_req) |=> osc_stable);

  p_extra_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> $past(osc_stable));

  p_run_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !reset_req) |=> run_en);

  p_fallback_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel != SEL_PRIMARY) |-> !osc_stable && !run_en);

  p_sel_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == SEL_PRIMARY) || (clk_sel == SEL_INTRC));
endmodule

bind rst_osc_seq rst_osc_seq_chk u_chk (.*);

// File: tb/rst_osc_seq_tb_top.sv
`timescale 1ns/1ps
module rst_osc_seq_tb_top;
  import rst_osc_pkg::*;

  localparam int unsigned T = 64;
  localparam int unsigned C = 40;

  logic clk = 1'b0, rst_n = 1'b0, reset_req = 1'b0;
  logic sleep_i = 1'b0, two_speed_en = 1'b0, prim_tick = 1'b0;
  logic [2:0] osc_mode = MODE_EC;
  logic hold_rst, run_en, osc_stable;
  logic [1:0] clk_sel;

  int checks = 0, fails = 0, cyc = 0, launch_cyc = 0;
  string cur_tag = "";

  typedef struct {
    int run_d;
    int stable_d;
    logic [1:0] sel_b;
  } exp_t;
  exp_t exp_q[$];

  logic prev_run = 1'b0, prev_st = 1'b0;
  logic [1:0] prev_sel = 2'b00;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rst_osc_seq #(.OST_TICKS(T), .CPU_TICKS(C)) dut_i (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .osc_mode(osc_mode),
    .sleep_i(sleep_i), .two_speed_en(two_speed_en), .prim_tick(prim_tick),
    .hold_rst(hold_rst), .run_en(run_en), .clk_sel(clk_sel), .osc_stable(osc_stable)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic exp_t predict(input logic [2:0] m, input bit cpu, input bit ts);
    exp_t e;
    bit x;
    int dost, dcpu;
    x = (m == MODE_LP) || (m == MODE_XT) || (m == MODE_HS);
    dost = x ? T + 1 : 1;
    dcpu = cpu ? C + 1 : 1;
    e.stable_d = dost;
    e.run_d    = ((dost > dcpu) ? dost : dcpu) + 2;
    e.sel_b    = (x && ts) ? SEL_INTRC : SEL_PRIMARY;
    return e;
  endfunction

  // Monitor: compare output rise times with the queued expectations.
  always @(negedge clk) begin
    int d;
    d = cyc - launch_cyc;
    if (rst_n && exp_q.size() > 0) begin
      if (osc_stable && !prev_st) begin
        chk(d == exp_q[0].stable_d, {"R2 R3 stable delay ", cur_tag}, d, exp_q[0].stable_d);
        chk(prev_sel == exp_q[0].sel_b, {"R8 clk_sel before stable ", cur_tag},
            int'(prev_sel), int'(exp_q[0].sel_b));
        chk(clk_sel == SEL_PRIMARY, {"R8 clk_sel after stable ", cur_tag}, int'(clk_sel), 0);
      end
      if (run_en && !prev_run) begin
        chk(d == exp_q[0].run_d, {"R5 run delay ", cur_tag}, d, exp_q[0].run_d);
        chk(!hold_rst, {"R7 hold released ", cur_tag}, int'(hold_rst), 0);
        void'(exp_q.pop_front());
      end
    end
    prev_run = run_en;
    prev_st  = osc_stable;
    prev_sel = clk_sel;
  end

  task automatic launch(input logic [2:0] m, input bit slp, input bit ts,
                        input int hold, input bit push, input string tag);
    @(negedge clk);
    osc_mode = m; sleep_i = slp; two_speed_en = ts; reset_req = 1'b1;
    repeat (hold) @(posedge clk);
    #1;
    launch_cyc = cyc;
    cur_tag = tag;
    exp_q.delete();
    if (push) exp_q.push_back(predict(m, slp, ts));
    @(negedge clk);
    reset_req = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, {"R5 release reached ", cur_tag}, exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R5 watchdog: actual %0d expected %0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    prim_tick = 1'b1;
    repeat (3) @(negedge clk);
    chk(hold_rst == 1'b1, "R1 power-on hold_rst", int'(hold_rst), 1);
    chk(run_en == 1'b0, "R1 power-on run_en", int'(run_en), 0);
    chk(clk_sel == SEL_PRIMARY, "R1 power-on clk_sel", int'(clk_sel), 0);
    chk(osc_stable == 1'b0, "R1 power-on osc_stable", int'(osc_stable), 0);

    // R4: the power-on exit always runs the CPU delay.
    @(negedge clk);
    #1;
    rst_n = 1'b1;
    launch_cyc = cyc;
    cur_tag = "R4 power-on external clock";
    exp_q.push_back(predict(MODE_EC, 1'b1, 1'b0));
    wait_done();

    // R1: a request while running clears everything on the next edge.
    @(negedge clk);
    reset_req = 1'b1;
    @(posedge clk);
    #1;
    chk(hold_rst == 1'b1, "R1 request hold_rst", int'(hold_rst), 1);
    chk(run_en == 1'b0, "R1 request run_en", int'(run_en), 0);
    chk(osc_stable == 1'b0, "R1 request osc_stable", int'(osc_stable), 0);
    chk(clk_sel == SEL_PRIMARY, "R1 request clk_sel", int'(clk_sel), 0);
    @(negedge clk);
    reset_req = 1'b0;

    launch(MODE_EC, 1'b0, 1'b0, 1, 1'b1, "R3 R4 external clock, awake");
    wait_done();
    launch(MODE_ERC, 1'b1, 1'b0, 1, 1'b1, "R3 R4 external RC, from sleep");
    wait_done();
    launch(MODE_INTRC, 1'b0, 1'b1, 1, 1'b1, "R3 R8 internal RC, two-speed");
    wait_done();
    launch(3'b111, 1'b0, 1'b0, 1, 1'b1, "R3 unused code");
    wait_done();
    launch(MODE_HS, 1'b0, 1'b0, 1, 1'b1, "R2 high-speed crystal");
    wait_done();
    launch(MODE_XT, 1'b1, 1'b0, 1, 1'b1, "R2 R5 standard crystal, parallel timers");
    wait_done();
    launch(MODE_LP, 1'b1, 1'b1, 1, 1'b1, "R8 low-power crystal, two-speed");
    wait_done();
    launch(MODE_EC, 1'b1, 1'b0, 4, 1'b1, "R12 long request");
    wait_done();

    // R11: restart in the middle of the wait.
    launch(MODE_HS, 1'b1, 1'b0, 1, 1'b1, "R11 first");
    repeat (20) @(negedge clk);
    launch(MODE_HS, 1'b1, 1'b0, 1, 1'b1, "R11 restart");
    wait_done();

    // R9: changes after the reset state are ignored.
    launch(MODE_HS, 1'b0, 1'b0, 1, 1'b1, "R9 late mode change");
    repeat (5) @(negedge clk);
    osc_mode = MODE_EC; two_speed_en = 1'b1; sleep_i = 1'b1;
    wait_done();

    // R10: no ticks, no progress; then count ticks edge by edge.
    prim_tick = 1'b0;
    launch(MODE_HS, 1'b0, 1'b0, 1, 1'b0, "R10 no ticks");
    repeat (100) @(negedge clk);
    chk(osc_stable == 1'b0, "R10 stable without ticks", int'(osc_stable), 0);
    chk(run_en == 1'b0, "R10 run without ticks", int'(run_en), 0);
    chk(hold_rst == 1'b1, "R7 hold without ticks", int'(hold_rst), 1);
    @(negedge clk);
    prim_tick = 1'b1;
    repeat (T - 1) @(negedge clk);
    chk(osc_stable == 1'b0, "R10 stable one tick early", int'(osc_stable), 0);
    @(negedge clk);
    chk(osc_stable == 1'b1, "R10 stable on last tick", int'(osc_stable), 1);
    chk(run_en == 1'b0, "R6 no run with stable", int'(run_en), 0);
    @(negedge clk);
    chk(run_en == 1'b0, "R6 settling cycle", int'(run_en), 0);
    @(negedge clk);
    chk(run_en == 1'b1, "R6 release after settling", int'(run_en), 1);
    repeat (10) @(negedge clk);
    chk(run_en == 1'b1, "R7 run stays high", int'(run_en), 1);

    summary();
    $finish;
  end
endmodule